// File: doc/BRIEF.md
# Dual configurable storage element pair

This block holds two one-bit storage cells, an upper and a lower one, that share a single set of control inputs. Build-time parameters set each cell to act as an edge-triggered flip-flop or as a level-sensitive transparent latch. They also set whether the force-high and force-low controls act on the clock edge or at once, and the polarity of every control input.

Each cell's data input comes from a fixed two-way selector. The upper cell takes its combinational input or its bypass input. The lower cell chooses the same way from its own pair.

Two control inputs drive the force functions. The `sr_i` input drives one of them and `rev_i` drives the opposite one, and a parameter decides which of the two is force-low. When both are active, the cell always resolves low. The block is meant to be instantiated many times in a fabric of logic tiles, with its parameters fixed per instance.

Top module: `dual_store_pair`

## Requirements
- R1: While `rst_ni` is low, both outputs are 0 at once, with no clock edge needed.
- R2: In flip-flop mode, a cell loads its selected data on the active clock edge when the enable is active and neither force control is active. A source parameter of 0 selects the combinational input and 1 selects the bypass input: `comb_hi_i`/`byp_hi_i` for the upper cell and `comb_lo_i`/`byp_lo_i` for the lower cell.
- R3: In flip-flop mode, with the enable inactive and no force control active, both outputs keep their value across clock edges.
- R4: With the synchronous style (`SR_STYLE` = 0), the force controls change the outputs only on an active clock edge. They act on that edge even when the enable is inactive, and between edges they have no effect.
- R5: When the force-low and force-high controls are active together, both outputs go to 0, in every mode and style.
- R6: With the asynchronous style in flip-flop mode, the force controls change the outputs immediately, without waiting for a clock edge.
- R7: With `SR_SETS` = 0, `sr_i` forces low and `rev_i` forces high. With `SR_SETS` = 1, the roles swap.
- R8: In latch mode, each output follows its selected data while both the gate (`clk_i`) and the gate enable (`ce_i`) are active.
- R9: In latch mode, the value present when the gate goes inactive is held. The output stays unchanged while either the gate or the gate enable is inactive.
- R10: In latch mode, an active force control changes the output immediately, whatever the state of the gate.
- R11: A polarity parameter of 1 makes the matching control active-low. An inverted clock makes flip-flops load on the falling edge of `clk_i` and ignore its rising edge.
- R12: Both cells share the clock, enable and force controls, but each cell stores its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low initialization, clears both cells |
| clk_i | input | 1 | Shared clock (flip-flop mode) or gate (latch mode) |
| ce_i | input | 1 | Shared clock enable or gate enable |
| sr_i | input | 1 | Shared primary force control |
| rev_i | input | 1 | Shared force control of the opposite function |
| comb_hi_i | input | 1 | Upper cell combinational data |
| byp_hi_i | input | 1 | Upper cell bypass data |
| comb_lo_i | input | 1 | Lower cell combinational data |
| byp_lo_i | input | 1 | Lower cell bypass data |
| q_hi_o | output | 1 | Upper cell output |
| q_lo_o | output | 1 | Lower cell output |

## Verification
Two pairs of functions can meet in one clock edge or gate window. The first pair is a data load and a force control; the second is force-high and force-low together. The bench provokes both. It drives enable and data together with `sr_i`, with `rev_i`, and with both, in synchronous, asynchronous and latch configurations. The result is judged as a force action beating the load, with force-low dominant. In the synchronous case, a force pulse placed between edges must leave the outputs untouched.

// File: rtl/dse_pkg.sv
package dse_pkg;
  typedef enum logic { MODE_FF = 1'b0, MODE_LATCH = 1'b1 } store_mode_e;
  typedef enum logic { SR_SYNC = 1'b0, SR_ASYNC = 1'b1 } sr_style_e;
  typedef enum logic { SRC_COMB = 1'b0, SRC_BYPASS = 1'b1 } data_src_e;
  localparam int unsigned NUM_CELLS = 2;
endpackage

// File: rtl/dse_ctrl_map.sv
module dse_ctrl_map #(
  parameter bit SR_SETS = 1'b0,
  parameter bit INV_CLK = 1'b0,
  parameter bit INV_CE  = 1'b0,
  parameter bit INV_SR  = 1'b0,
  parameter bit INV_REV = 1'b0
) (
  input  logic clk_i,
  input  logic ce_i,
  input  logic sr_i,
  input  logic rev_i,
  output logic clk_o,
  output logic en_o,
  output logic clr_o,
  output logic set_o
);
  logic sr_act, rev_act;

  assign clk_o   = clk_i ^ INV_CLK;
  assign en_o    = ce_i ^ INV_CE;
  assign sr_act  = sr_i ^ INV_SR;
  assign rev_act = rev_i ^ INV_REV;

  // SR carries the configured function, REV the opposite one
  if (SR_SETS) begin : g_sr_sets
    assign set_o = sr_act;
    assign clr_o = rev_act;
  end else begin : g_sr_clears
    assign clr_o = sr_act;
    assign set_o = rev_act;
  end
endmodule

// File: rtl/dse_src_sel.sv
module dse_src_sel
  import dse_pkg::*;
#(
  parameter data_src_e SRC = SRC_COMB
) (
  input  logic comb_i,
  input  logic byp_i,
  output logic d_o
);
  if (SRC == SRC_BYPASS) begin : g_byp
    assign d_o = byp_i;
  end else begin : g_comb
    assign d_o = comb_i;
  end
endmodule

// File: rtl/dse_cell.sv
module dse_cell
  import dse_pkg::*;
#(
  parameter store_mode_e MODE  = MODE_FF,
  parameter sr_style_e   STYLE = SR_SYNC
) (
  input  logic rst_ni,
  input  logic clk_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  if (MODE == MODE_LATCH) begin : g_latch
    // force controls act at once regardless of style; clear dominates
    always_latch begin
      if (!rst_ni || clr_i)   q_q = 1'b0;
      else if (set_i)         q_q = 1'b1;
      else if (clk_i && en_i) q_q = d_i;
    end
  end else if (STYLE == SR_SYNC) begin : g_ff_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q <= 1'b0;
      else if (clr_i)  q_q <= 1'b0;
      else if (set_i)  q_q <= 1'b1;
      else if (en_i)   q_q <= d_i;
    end
  end else begin : g_ff_async
    logic kill;
    assign kill = !rst_ni || clr_i;
    always_ff @(posedge clk_i or posedge kill or posedge set_i) begin
      if (kill)        q_q <= 1'b0;
      else if (set_i)  q_q <= 1'b1;
      else if (en_i)   q_q <= d_i;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/dual_store_pair.sv
module dual_store_pair
  import dse_pkg::*;
#(
  parameter store_mode_e CELL_MODE = MODE_FF,
  parameter sr_style_e   SR_STYLE  = SR_SYNC,
  parameter bit          SR_SETS   = 1'b0,
  parameter bit          INV_CLK   = 1'b0,
  parameter bit          INV_CE    = 1'b0,
  parameter bit          INV_SR    = 1'b0,
  parameter bit          INV_REV   = 1'b0,
  parameter data_src_e   SRC_HI    = SRC_COMB,
  parameter data_src_e   SRC_LO    = SRC_COMB
) (
  input  logic rst_ni,
  input  logic clk_i,
  input  logic ce_i,
  input  logic sr_i,
  input  logic rev_i,
  input  logic comb_hi_i,
  input  logic byp_hi_i,
  input  logic comb_lo_i,
  input  logic byp_lo_i,
  output logic q_hi_o,
  output logic q_lo_o
);
  localparam int unsigned LO = 0;
  localparam int unsigned HI = 1;

  logic clk_n, en_n, clr_n, set_n;
  logic [NUM_CELLS-1:0] comb_v, byp_v, d_v, q_v;

  assign comb_v = {comb_hi_i, comb_lo_i};
  assign byp_v  = {byp_hi_i, byp_lo_i};

  dse_ctrl_map #(
    .SR_SETS(SR_SETS), .INV_CLK(INV_CLK), .INV_CE(INV_CE),
    .INV_SR(INV_SR), .INV_REV(INV_REV)
  ) u_ctrl (
    .clk_i(clk_i), .ce_i(ce_i), .sr_i(sr_i), .rev_i(rev_i),
    .clk_o(clk_n), .en_o(en_n), .clr_o(clr_n), .set_o(set_n)
  );

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    localparam data_src_e SRC = (c == HI) ? SRC_HI : SRC_LO;

    dse_src_sel #(.SRC(SRC)) u_sel (
      .comb_i(comb_v[c]), .byp_i(byp_v[c]), .d_o(d_v[c])
    );

    dse_cell #(.MODE(CELL_MODE), .STYLE(SR_STYLE)) u_cell (
      .rst_ni(rst_ni), .clk_i(clk_n), .en_i(en_n),
      .clr_i(clr_n), .set_i(set_n), .d_i(d_v[c]), .q_o(q_v[c])
    );
  end

  assign q_hi_o = q_v[HI];
  assign q_lo_o = q_v[LO];
endmodule

// File: rtl/dual_store_pair_chk.sv
module dual_store_pair_chk
  import dse_pkg::*;
#(
  parameter store_mode_e CELL_MODE = MODE_FF,
  parameter sr_style_e   SR_STYLE  = SR_SYNC,
  parameter bit          SR_SETS   = 1'b0,
  parameter bit          INV_CLK   = 1'b0,
  parameter bit          INV_CE    = 1'b0,
  parameter bit          INV_SR    = 1'b0,
  parameter bit          INV_REV   = 1'b0,
  parameter data_src_e   SRC_HI    = SRC_COMB,
  parameter data_src_e   SRC_LO    = SRC_COMB
) (
  input logic rst_ni,
  input logic clk_i,
  input logic ce_i,
  input logic sr_i,
  input logic rev_i,
  input logic comb_hi_i,
  input logic byp_hi_i,
  input logic comb_lo_i,
  input logic byp_lo_i,
  input logic q_hi_o,
  input logic q_lo_o
);
  logic ck, en_a, sr_a, rev_a, lo_a, hi_a, d_hi, d_lo;

  assign ck    = clk_i ^ INV_CLK;
  assign en_a  = ce_i ^ INV_CE;
  assign sr_a  = sr_i ^ INV_SR;
  assign rev_a = rev_i ^ INV_REV;
  assign lo_a  = SR_SETS ? rev_a : sr_a;
  assign hi_a  = SR_SETS ? sr_a : rev_a;
  assign d_hi  = (SRC_HI == SRC_BYPASS) ? byp_hi_i : comb_hi_i;
  assign d_lo  = (SRC_LO == SRC_BYPASS) ? byp_lo_i : comb_lo_i;

  if (CELL_MODE == MODE_FF && SR_STYLE == SR_SYNC) begin : g_sync
    a_r2_capture: assert property (@(posedge ck) disable iff (!rst_ni)
      en_a && !lo_a && !hi_a |=> q_hi_o == $past(d_hi) && q_lo_o == $past(d_lo));
    a_r3_hold: assert property (@(posedge ck) disable iff (!rst_ni)
      !en_a && !lo_a && !hi_a |=> $stable(q_hi_o) && $stable(q_lo_o));
    a_r5_low_wins: assert property (@(posedge ck) disable iff (!rst_ni)
      lo_a |=> !q_hi_o && !q_lo_o);
    a_r4_set_edge: assert property (@(posedge ck) disable iff (!rst_ni)
      hi_a && !lo_a |=> q_hi_o && q_lo_o);
  end else if (CELL_MODE == MODE_FF) begin : g_async
    a_r6_async_low: assert property (@(posedge ck) disable iff (!rst_ni)
      lo_a |-> !q_hi_o && !q_lo_o);
    a_r6_async_high: assert property (@(posedge ck) disable iff (!rst_ni)
      hi_a && !lo_a |-> q_hi_o && q_lo_o);
  end
endmodule

bind dual_store_pair dual_store_pair_chk #(
  .CELL_MODE(CELL_MODE), .SR_STYLE(SR_STYLE), .SR_SETS(SR_SETS),
  .INV_CLK(INV_CLK), .INV_CE(INV_CE), .INV_SR(INV_SR), .INV_REV(INV_REV),
  .SRC_HI(SRC_HI), .SRC_LO(SRC_LO)
) u_chk (.*);

// File: tb/dual_store_pair_test.sv
module dual_store_pair_test;
  import dse_pkg::*;

  int total = 0;
  int bad = 0;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  // main: ff, sync, SR clears, upper comb, lower bypass
  logic m_ce = 0, m_sr = 0, m_rev = 0, m_y = 0, m_by = 0, m_x = 0, m_bx = 0;
  logic m_qh, m_ql;
  dual_store_pair #(.SRC_LO(SRC_BYPASS)) uut (
    .rst_ni(rst_ni), .clk_i(clk), .ce_i(m_ce), .sr_i(m_sr), .rev_i(m_rev),
    .comb_hi_i(m_y), .byp_hi_i(m_by), .comb_lo_i(m_x), .byp_lo_i(m_bx),
    .q_hi_o(m_qh), .q_lo_o(m_ql));

  // ff, async, SR presets, upper bypass, lower comb
  logic a_ce = 0, a_sr = 0, a_rev = 0, a_by = 0, a_x = 0;
  logic a_qh, a_ql;
  dual_store_pair #(.SR_STYLE(SR_ASYNC), .SR_SETS(1'b1), .SRC_HI(SRC_BYPASS)) uut_async (
    .rst_ni(rst_ni), .clk_i(clk), .ce_i(a_ce), .sr_i(a_sr), .rev_i(a_rev),
    .comb_hi_i(~a_by), .byp_hi_i(a_by), .comb_lo_i(a_x), .byp_lo_i(~a_x),
    .q_hi_o(a_qh), .q_lo_o(a_ql));

  // ff, sync, every control inverted
  logic i_ce = 1, i_sr = 1, i_rev = 1, i_y = 0, i_x = 0;
  logic i_qh, i_ql;
  dual_store_pair #(.INV_CLK(1'b1), .INV_CE(1'b1), .INV_SR(1'b1), .INV_REV(1'b1)) uut_inv (
    .rst_ni(rst_ni), .clk_i(clk), .ce_i(i_ce), .sr_i(i_sr), .rev_i(i_rev),
    .comb_hi_i(i_y), .byp_hi_i(~i_y), .comb_lo_i(i_x), .byp_lo_i(~i_x),
    .q_hi_o(i_qh), .q_lo_o(i_ql));

  // latch, SR clears, upper comb, lower bypass
  logic l_g = 0, l_ge = 0, l_sr = 0, l_rev = 0, l_y = 0, l_bx = 0;
  logic l_qh, l_ql;
  dual_store_pair #(.CELL_MODE(MODE_LATCH), .SRC_LO(SRC_BYPASS)) uut_lat (
    .rst_ni(rst_ni), .clk_i(l_g), .ce_i(l_ge), .sr_i(l_sr), .rev_i(l_rev),
    .comb_hi_i(l_y), .byp_hi_i(~l_y), .comb_lo_i(~l_bx), .byp_lo_i(l_bx),
    .q_hi_o(l_qh), .q_lo_o(l_ql));

  // {ce, sr, rev, y, by, x, bx, exp_hi, exp_lo}
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    9'b100100111, 9'b100011000, 9'b000100100, 9'b100100111, 9'b110100100,
    9'b001000011, 9'b111100100, 9'b001000011, 9'b010100100, 9'b100000101};

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    // R1: reset state of every configuration
    chk("R1 m_hi", m_qh, 1'b0); chk("R1 m_lo", m_ql, 1'b0);
    chk("R1 a_hi", a_qh, 1'b0); chk("R1 i_lo", i_ql, 1'b0);
    chk("R1 l_hi", l_qh, 1'b0);
    @(negedge clk); rst_ni = 1'b1;

    // R2 R3 R4 R5 R12: vector walk on the synchronous flip-flop
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {m_ce, m_sr, m_rev, m_y, m_by, m_x, m_bx} = VEC[k][8:2];
      @(posedge clk); #2;
      chk($sformatf("R2/R3/R4/R5/R12 vec%0d hi", k), m_qh, VEC[k][1]);
      chk($sformatf("R2/R3/R4/R5/R12 vec%0d lo", k), m_ql, VEC[k][0]);
    end

    // R4: force pulse between edges has no effect
    @(negedge clk); m_ce = 1'b0; m_sr = 1'b0; m_rev = 1'b0;
    #1 m_sr = 1'b1;
    #1 chk("R4 midcycle lo", m_ql, 1'b1);
    m_rev = 1'b1; m_sr = 1'b0;
    #1 chk("R4 midcycle hi", m_qh, 1'b0);
    m_rev = 1'b0;
    @(posedge clk); #2;
    chk("R4 after edge hi", m_qh, 1'b0); chk("R4 after edge lo", m_ql, 1'b1);

    // R2 R6 R7 R5: asynchronous flip-flop, SR presets, REV clears
    @(negedge clk); a_ce = 1'b1; a_by = 1'b1; a_x = 1'b0;
    @(posedge clk); #2;
    chk("R2 async sel hi", a_qh, 1'b1); chk("R2 async sel lo", a_ql, 1'b0);
    @(negedge clk); a_ce = 1'b0; a_x = 1'b1;
    #1 a_rev = 1'b1;
    #1 chk("R6 R7 rev clears hi", a_qh, 1'b0);
    a_rev = 1'b0;
    #1 a_sr = 1'b1;
    #1 chk("R6 R7 sr presets lo", a_ql, 1'b1);
    a_sr = 1'b0;
    @(posedge clk); #2;
    chk("R3 async hold lo", a_ql, 1'b1);
    @(negedge clk); #1 a_sr = 1'b1;
    #1 a_rev = 1'b1;
    #1 chk("R5 async both hi", a_qh, 1'b0); chk("R5 async both lo", a_ql, 1'b0);
    a_sr = 1'b0; a_rev = 1'b0;

    // R11: inverted controls, falling-edge capture
    @(negedge clk); #1 i_ce = 1'b0; i_y = 1'b1; i_x = 1'b1;
    @(posedge clk); #1 chk("R11 rising ignored", i_qh, 1'b0);
    @(negedge clk); #1 chk("R11 falling capture hi", i_qh, 1'b1);
    chk("R11 falling capture lo", i_ql, 1'b1);
    i_sr = 1'b0;
    @(posedge clk); #1 chk("R11 R4 clear waits edge", i_qh, 1'b1);
    @(negedge clk); #1 chk("R11 active-low clear", i_ql, 1'b0);
    i_sr = 1'b1; i_ce = 1'b1; i_rev = 1'b0;
    @(negedge clk); #1 chk("R11 R4 set with enable off", i_qh, 1'b1);
    i_rev = 1'b1;

    // R8 R9 R10 R5: latch mode, gate driven directly
    #2 l_g = 1'b1; l_ge = 1'b1; l_y = 1'b1; l_bx = 1'b1;
    #1 chk("R8 transparent hi", l_qh, 1'b1); chk("R8 transparent lo", l_ql, 1'b1);
    l_y = 1'b0;
    #1 chk("R8 follows", l_qh, 1'b0);
    l_y = 1'b1;
    #1 l_g = 1'b0;
    #1 l_y = 1'b0; l_bx = 1'b0;
    #1 chk("R9 held after gate fall", l_qh, 1'b1);
    l_g = 1'b1; l_ge = 1'b0;
    #1 chk("R9 gate enable off", l_ql, 1'b1);
    l_g = 1'b0;
    #1 l_sr = 1'b1;
    #1 chk("R10 immediate clear", l_qh, 1'b0);
    l_sr = 1'b0;
    #1 l_rev = 1'b1;
    #1 chk("R10 immediate set", l_ql, 1'b1);
    l_sr = 1'b1;
    #1 chk("R5 latch both", l_qh, 1'b0);
    l_sr = 1'b0; l_rev = 1'b0;

    // R1: asynchronous reset mid-cycle
    @(negedge clk); #1 rst_ni = 1'b0;
    #1 chk("R1 async reset", m_ql, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule